// File: doc/BRIEF.md
# Merging Posted Write Buffer

This block sits between a processor core's store path and an external memory bus. It posts stores so that the core can continue without waiting for the bus. It holds up to eight pending writes. Each pending write covers one 16-byte aligned region and carries a valid flag for each byte. A write can therefore hold any mix of 1 to 16 bytes. When merging is switched on, a store that lands in the same region as the newest pending write is folded into that write, so that several small stores leave the chip as one bus transaction.

Software controls three things: a global enable, a merge enable and a flush request. A store is buffered only when the buffer is enabled, address translation is on and the store's page attribute marks it bufferable. Any other store bypasses the storage and goes to the bus directly, after every older buffered write has left. A status output reports when nothing is pending and no bus write is in progress.

Top module: `merge_post_wbuf`

## Requirements
- R1: After reset the buffer holds nothing: `wb_empty` is 1, `bus_valid` and `flush_busy` are 0, and `st_ready` is 1 for a bufferable store.
- R2: A buffered store leaves as one bus write. `bus_addr` is the region base (address bits [3:0] zero). `bus_strb` bit i marks byte lane i, which is `data[8i+7:8i]`. Lanes without a strobe are driven as zero.
- R3: A store is buffered only when `cfg_buf_en`, `cfg_xlat_en` and `st_bufable` are all 1. Any other store is a pass-through. It is presented on the bus in the same cycle with its address unchanged, `st_ready` follows `bus_ready`, and it is held back while any buffered write is pending.
- R4: Buffered writes reach the bus strictly in the order they were accepted.
- R5: With `cfg_merge_en` = 1, a store to the same region as the newest pending write is merged into it when that write is not at the head. The strobes are ORed, and bytes from the later store replace earlier bytes in the same lane.
- R6: With `cfg_merge_en` = 0, every buffered store becomes a write of its own, even when it targets the region of the newest pending write.
- R7: The write at the head, which is the one being presented on the bus, is never merged into. A store to its region becomes a new write.
- R8: At most 8 writes are held. With 8 pending, `st_ready` is 0 for bufferable stores until one write drains.
- R9: A one-cycle `flush_req` raises `flush_busy` while writes are pending. While `flush_busy` is high, no store is accepted. `flush_busy` falls in the cycle the last pending write is accepted by the bus.
- R10: `wb_empty` is 1 exactly when no buffered write is pending and no pass-through store is being presented.
- R11: While `bus_ready` is 0, the address, strobes and data of a presented buffered write hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_buf_en | input | 1 | Global buffer enable |
| cfg_xlat_en | input | 1 | Address translation is on |
| cfg_merge_en | input | 1 | Merge enable |
| flush_req | input | 1 | One-cycle flush request |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| st_addr | input | 32 | Store byte address |
| st_data | input | 128 | Store data, one byte per lane |
| st_be | input | 16 | Store byte enables |
| st_bufable | input | 1 | Page attribute: store may be buffered |
| bus_valid | output | 1 | Bus write request |
| bus_ready | input | 1 | Bus accepts the write |
| bus_addr | output | 32 | Write address |
| bus_data | output | 128 | Write data, zero in unstrobed lanes |
| bus_strb | output | 16 | Write byte strobes |
| wb_empty | output | 1 | Nothing pending and no bus write in progress |
| flush_busy | output | 1 | Flush in progress |

## Verification
The bench drives a store to the region of the head write while the bus is stalled. A design that merges into the write being presented would change the strobes on the bus in the middle of a transfer, or would send one write where two are expected. It checks that overlapping bytes from a later merged store win, that merging stops when disabled, and that a ninth store is refused until exactly one write drains. An off-by-one full test would drop or corrupt a write in that case. Pass-through stores are issued behind a pending buffered write and under each gating condition. A design that let them overtake would reverse the order seen on the bus. The bench also checks that during a flush, stores stall and the empty flag rises at the moment the busy flag falls.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
// Shared types for the merging posted write buffer.
// Assumes: every module of the buffer imports this package.
package wbuf_pkg;

    // Action taken on the core store presented this cycle
    typedef enum logic [1:0] {
        RT_IDLE  = 2'd0,   // no store accepted
        RT_NEW   = 2'd1,   // store opens a new pending write
        RT_MERGE = 2'd2,   // store folds into the newest pending write
        RT_PASS  = 2'd3    // store goes straight to the bus
    } route_e;

    // Defaults for the buffer geometry
    localparam int unsigned WB_DEPTH_DEF = 8;
    localparam int unsigned WB_LANES_DEF = 16;
    localparam int unsigned WB_AW_DEF    = 32;

endpackage

// File: rtl/wbuf_admit.sv
`timescale 1ns/1ps
// Store admission: decides, for each core store, whether it is stalled,
// passed to the bus, merged into the newest pending write or given a new
// slot. It also holds the flush state.
// Assumes: q_count is the number of pending writes after the previous edge,
// and q_pop is high when the head write is accepted by the bus this cycle.
module wbuf_admit
    import wbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH_DEF,
    parameter int TAGW  = 28,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_buf_en,
    input  logic            cfg_xlat_en,
    input  logic            cfg_merge_en,
    input  logic            flush_req,
    input  logic            st_valid,
    input  logic            st_bufable,
    input  logic [TAGW-1:0] st_tag,
    input  logic [TAGW-1:0] tail_tag,
    input  logic [CW-1:0]   q_count,
    input  logic            q_pop,
    input  logic            bus_ready,
    output logic            st_ready,
    output logic            pass_valid,
    output route_e          route,
    output logic            flush_busy
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] TWO_CNT  = CW'(2);

    logic          buf_path;
    logic          q_full;
    logic          q_empty;
    logic          merge_hit;
    logic          fire;
    logic          flushing;
    logic [CW-1:0] cnt_next;

    // Classify the store and derive the handshake
    always_comb begin
        buf_path   = cfg_buf_en && cfg_xlat_en && st_bufable;
        q_full     = (q_count == FULL_CNT);
        q_empty    = (q_count == '0);
        // the newest write is never the head once two or more are pending
        merge_hit  = cfg_merge_en && (q_count >= TWO_CNT) && (tail_tag == st_tag);
        pass_valid = st_valid && !buf_path && !flushing && q_empty;
        if (flushing)
            st_ready = 1'b0;
        else if (buf_path)
            st_ready = !q_full;
        else
            st_ready = q_empty && bus_ready;
        fire = st_valid && st_ready;
        if (!fire)
            route = RT_IDLE;
        else if (!buf_path)
            route = RT_PASS;
        else if (merge_hit)
            route = RT_MERGE;
        else
            route = RT_NEW;
        cnt_next = q_count + CW'(route == RT_NEW) - CW'(q_pop);
    end

    // Flush state: held until the pending count reaches zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            flushing <= 1'b0;
        else
            flushing <= (flushing || flush_req) && (cnt_next != '0);
    end

    assign flush_busy = flushing;

    // R8
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == FULL_CNT) |-> (route != RT_NEW && route != RT_MERGE));

endmodule

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
// Pending-write storage: a circular set of slots, each holding a region
// tag, per-byte valid flags and data. It opens new slots, merges stores into
// the newest slot and retires the head.
// Assumes: RT_NEW never arrives when full, RT_MERGE only with two or more
// pending, and pop only when something is pending.
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH_DEF,
    parameter int LANES = WB_LANES_DEF,
    parameter int TAGW  = 28,
    localparam int DW   = LANES * 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  route_e           route,
    input  logic [TAGW-1:0]  st_tag,
    input  logic [DW-1:0]    st_data,
    input  logic [LANES-1:0] st_be,
    input  logic             pop,
    output logic [CW-1:0]    q_count,
    output logic [TAGW-1:0]  head_tag,
    output logic [DW-1:0]    head_data,
    output logic [LANES-1:0] head_be,
    output logic [TAGW-1:0]  tail_tag
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [TAGW-1:0]  tag_q  [DEPTH];
    logic [LANES-1:0] be_q   [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [PW-1:0]    hd;
    logic [PW-1:0]    tl;
    logic [PW-1:0]    newest;
    logic [CW-1:0]    count;
    logic             push;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PW'(1);
    endfunction

    // Locate the newest slot and decode the push
    always_comb begin
        newest = (tl == '0) ? LAST_IDX : tl - PW'(1);
        push   = (route == RT_NEW);
    end

    // Slot contents: open a slot or merge bytes into the newest one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) begin
                tag_q[d]  <= '0;
                be_q[d]   <= '0;
                data_q[d] <= '0;
            end
        end else if (push) begin
            tag_q[tl] <= st_tag;
            be_q[tl]  <= st_be;
            for (int i = 0; i < LANES; i++)
                data_q[tl][i*8 +: 8] <= st_be[i] ? st_data[i*8 +: 8] : 8'h00;
        end else if (route == RT_MERGE) begin
            be_q[newest] <= be_q[newest] | st_be;
            for (int i = 0; i < LANES; i++)
                if (st_be[i])
                    data_q[newest][i*8 +: 8] <= st_data[i*8 +: 8];
        end
    end

    // Head, tail pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd    <= '0;
            tl    <= '0;
            count <= '0;
        end else begin
            if (pop)  hd <= step(hd);
            if (push) tl <= step(tl);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign q_count   = count;
    assign head_tag  = tag_q[hd];
    assign head_be   = be_q[hd];
    assign head_data = data_q[hd];
    assign tail_tag  = tag_q[newest];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R8
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != FULL_CNT));

    // R7
    merge_not_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_MERGE) |-> (count >= CW'(2)));

    // R4
    pop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    // R11
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !pop) |=>
        ($stable(head_tag) && $stable(head_be) && $stable(head_data)));

endmodule

// File: rtl/wbuf_port.sv
`timescale 1ns/1ps
// Bus-side port: presents the head write, or a pass-through store when
// nothing is pending, and reports the idle state.
// Assumes: pass_valid is only raised while no write is pending.
module wbuf_port #(
    parameter int LANES = 16,
    parameter int AW    = 32,
    localparam int DW   = LANES * 8,
    localparam int OFF  = $clog2(LANES),
    localparam int TAGW = AW - OFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [TAGW-1:0]  head_tag,
    input  logic [DW-1:0]    head_data,
    input  logic [LANES-1:0] head_be,
    input  logic             pass_valid,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic [LANES-1:0] st_be,
    input  logic             bus_ready,
    output logic             bus_valid,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_data,
    output logic [LANES-1:0] bus_strb,
    output logic             q_pop,
    output logic             wb_empty
);

    logic [DW-1:0] pass_data;

    // Zero the unstrobed lanes of a pass-through store
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pass_data[i*8 +: 8] = st_be[i] ? st_data[i*8 +: 8] : 8'h00;
    end

    // Select the write shown on the bus
    always_comb begin
        if (head_valid) begin
            bus_valid = 1'b1;
            bus_addr  = {head_tag, {OFF{1'b0}}};
            bus_data  = head_data;
            bus_strb  = head_be;
        end else begin
            bus_valid = pass_valid;
            bus_addr  = st_addr;
            bus_data  = pass_data;
            bus_strb  = st_be;
        end
        q_pop    = head_valid && bus_ready;
        wb_empty = !head_valid && !pass_valid;
    end

    // R3
    pass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> !head_valid);

endmodule

// File: rtl/merge_post_wbuf.sv
`timescale 1ns/1ps
// Merging posted write buffer, top level. Core stores are admitted, merged
// or passed through, held in order and drained to the bus as byte-strobed
// writes.
// Assumes: the core holds a store steady until st_ready, and the bus holds
// bus_ready semantics of a valid/ready handshake.
module merge_post_wbuf
    import wbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH_DEF,
    parameter int LANES = WB_LANES_DEF,
    parameter int AW    = WB_AW_DEF,
    localparam int DW   = LANES * 8,
    localparam int OFF  = $clog2(LANES),
    localparam int TAGW = AW - OFF,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_buf_en,
    input  logic             cfg_xlat_en,
    input  logic             cfg_merge_en,
    input  logic             flush_req,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic [LANES-1:0] st_be,
    input  logic             st_bufable,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_data,
    output logic [LANES-1:0] bus_strb,
    output logic             wb_empty,
    output logic             flush_busy
);

    route_e          route;
    logic            pass_valid;
    logic            q_pop;
    logic [CW-1:0]   q_count;
    logic [TAGW-1:0] head_tag;
    logic [TAGW-1:0] tail_tag;
    logic [DW-1:0]   head_data;
    logic [LANES-1:0] head_be;
    logic [TAGW-1:0] st_tag;
    logic            head_valid;

    assign st_tag     = st_addr[AW-1:OFF];
    assign head_valid = (q_count != '0);

    wbuf_admit #(.DEPTH(DEPTH), .TAGW(TAGW)) u_admit (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_buf_en   (cfg_buf_en),
        .cfg_xlat_en  (cfg_xlat_en),
        .cfg_merge_en (cfg_merge_en),
        .flush_req    (flush_req),
        .st_valid     (st_valid),
        .st_bufable   (st_bufable),
        .st_tag       (st_tag),
        .tail_tag     (tail_tag),
        .q_count      (q_count),
        .q_pop        (q_pop),
        .bus_ready    (bus_ready),
        .st_ready     (st_ready),
        .pass_valid   (pass_valid),
        .route        (route),
        .flush_busy   (flush_busy)
    );

    wbuf_store #(.DEPTH(DEPTH), .LANES(LANES), .TAGW(TAGW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .route     (route),
        .st_tag    (st_tag),
        .st_data   (st_data),
        .st_be     (st_be),
        .pop       (q_pop),
        .q_count   (q_count),
        .head_tag  (head_tag),
        .head_data (head_data),
        .head_be   (head_be),
        .tail_tag  (tail_tag)
    );

    wbuf_port #(.LANES(LANES), .AW(AW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_tag   (head_tag),
        .head_data  (head_data),
        .head_be    (head_be),
        .pass_valid (pass_valid),
        .st_addr    (st_addr),
        .st_data    (st_data),
        .st_be      (st_be),
        .bus_ready  (bus_ready),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_strb   (bus_strb),
        .q_pop      (q_pop),
        .wb_empty   (wb_empty)
    );

    // R3
    pass_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_PASS) |-> (bus_valid && bus_ready));

    // R10
    empty_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_empty |-> !flush_busy);

    // R9
    flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> (q_count == '0));

endmodule

// File: tb/tb_merge_post_wbuf.sv
`timescale 1ns/1ps
// Directed bench for the merging posted write buffer.
module tb_merge_post_wbuf;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_buf_en = 1'b1, cfg_xlat_en = 1'b1, cfg_merge_en = 1'b1;
    logic         flush_req = 1'b0;
    logic         st_valid = 1'b0, st_bufable = 1'b1;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [127:0] st_data = '0;
    logic [15:0]  st_be = '0;
    logic         bus_valid, bus_ready = 1'b0;
    logic [31:0]  bus_addr;
    logic [127:0] bus_data;
    logic [15:0]  bus_strb;
    logic         wb_empty, flush_busy;

    int tests = 0, fails = 0;
    int nw = 0, ne = 0;
    logic [31:0]  got_addr [32];
    logic [15:0]  got_strb [32];
    logic [127:0] got_data [32];
    logic [31:0]  exp_addr [32];
    logic [15:0]  exp_strb [32];
    logic [127:0] exp_data [32];

    merge_post_wbuf dut (
        .clk(clk), .rst_n(rst_n), .cfg_buf_en(cfg_buf_en), .cfg_xlat_en(cfg_xlat_en),
        .cfg_merge_en(cfg_merge_en), .flush_req(flush_req), .st_valid(st_valid),
        .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_bufable(st_bufable), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_strb(bus_strb),
        .wb_empty(wb_empty), .flush_busy(flush_busy)
    );

    always #5 clk = ~clk;

    // Bus monitor: log every accepted write, sampled mid-cycle
    always begin
        @(negedge clk);
        #2;
        if (rst_n && bus_valid && bus_ready && nw < 32) begin
            got_addr[nw] = bus_addr;
            got_strb[nw] = bus_strb;
            got_data[nw] = bus_data;
            nw++;
        end
    end

    function automatic logic [127:0] pat(input logic [7:0] s);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = s + 8'(i * 17);
        return r;
    endfunction

    function automatic logic [127:0] lay(input logic [127:0] old, input logic [127:0] d,
                                         input logic [15:0] be);
        logic [127:0] r = old;
        for (int i = 0; i < 16; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic store(input logic [31:0] a, input logic [127:0] d,
                         input logic [15:0] be, input logic bf);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_bufable = bf;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        bit done = 1'b0;
        @(negedge clk);
        bus_ready = 1'b1;
        for (int k = 0; k < 60 && !done; k++) begin
            @(negedge clk); #1;
            if (wb_empty) done = 1'b1;
        end
        chk(done, req, 0, 1);
    endtask

    task automatic clear_log();
        nw = 0; ne = 0;
    endtask

    task automatic expect_wr(input logic [31:0] a, input logic [15:0] s, input logic [127:0] d);
        exp_addr[ne] = a; exp_strb[ne] = s; exp_data[ne] = d; ne++;
    endtask

    task automatic verify(input string req);
        chk(nw == ne, {req, " write count"}, nw, ne);
        for (int i = 0; i < ne && i < nw; i++) begin
            chk(got_addr[i] == exp_addr[i], {req, " addr"}, got_addr[i], exp_addr[i]);
            chk(got_strb[i] == exp_strb[i], {req, " strb"}, got_strb[i], exp_strb[i]);
            chk(got_data[i] == exp_data[i], {req, " data"}, got_data[i], exp_data[i]);
        end
    endtask

    // R1: state right after reset
    task automatic t_reset();
        @(negedge clk); #1;
        chk(wb_empty == 1'b1, "R1 wb_empty", wb_empty, 1);
        chk(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
        chk(flush_busy == 1'b0, "R1 flush_busy", flush_busy, 0);
        chk(st_ready == 1'b1, "R1 st_ready", st_ready, 1);
    endtask

    // R2, R4: distinct regions drain in order with masked lanes
    task automatic t_order();
        clear_log();
        bus_ready = 1'b0;
        store(32'h100, pat(8'h01), 16'h000F, 1'b1);
        store(32'h200, pat(8'h02), 16'hF000, 1'b1);
        store(32'h300, pat(8'h03), 16'h00F0, 1'b1);
        idle();
        expect_wr(32'h100, 16'h000F, lay('0, pat(8'h01), 16'h000F));
        expect_wr(32'h200, 16'hF000, lay('0, pat(8'h02), 16'hF000));
        expect_wr(32'h300, 16'h00F0, lay('0, pat(8'h03), 16'h00F0));
        drain("R4 drain");
        verify("R2 R4 order");
    endtask

    // R5: merge into newest, later bytes win
    task automatic t_merge();
        logic [127:0] m;
        clear_log();
        bus_ready = 1'b0;
        cfg_merge_en = 1'b1;
        store(32'h400, pat(8'h10), 16'hFFFF, 1'b1);
        store(32'h500, pat(8'h20), 16'h0003, 1'b1);
        store(32'h500, pat(8'h30), 16'h0006, 1'b1);
        store(32'h500, pat(8'h40), 16'h0100, 1'b1);
        idle();
        m = lay(lay(lay('0, pat(8'h20), 16'h0003), pat(8'h30), 16'h0006), pat(8'h40), 16'h0100);
        expect_wr(32'h400, 16'hFFFF, pat(8'h10));
        expect_wr(32'h500, 16'h0107, m);
        drain("R5 drain");
        verify("R5 merge");
    endtask

    // R7, R11: head write is never merged and holds while stalled
    task automatic t_head();
        clear_log();
        bus_ready = 1'b0;
        store(32'h600, pat(8'h50), 16'h0001, 1'b1);
        store(32'h600, pat(8'h60), 16'h0002, 1'b1);
        idle();
        #1;
        chk(bus_strb == 16'h0001, "R7 head strb unchanged", bus_strb, 16'h0001);
        @(negedge clk); #1;
        chk(bus_addr == 32'h600 && bus_valid, "R11 head held", bus_addr, 32'h600);
        expect_wr(32'h600, 16'h0001, lay('0, pat(8'h50), 16'h0001));
        expect_wr(32'h600, 16'h0002, lay('0, pat(8'h60), 16'h0002));
        drain("R7 drain");
        verify("R7 no head merge");
    endtask

    // R6: merging disabled
    task automatic t_nomerge();
        clear_log();
        bus_ready = 1'b0;
        cfg_merge_en = 1'b0;
        store(32'h700, pat(8'h70), 16'hFFFF, 1'b1);
        store(32'h800, pat(8'h80), 16'h0001, 1'b1);
        store(32'h800, pat(8'h90), 16'h0002, 1'b1);
        idle();
        expect_wr(32'h700, 16'hFFFF, pat(8'h70));
        expect_wr(32'h800, 16'h0001, lay('0, pat(8'h80), 16'h0001));
        expect_wr(32'h800, 16'h0002, lay('0, pat(8'h90), 16'h0002));
        drain("R6 drain");
        verify("R6 no merge");
        cfg_merge_en = 1'b1;
    endtask

    // R8: eight pending refuses a ninth until one drains
    task automatic t_full();
        clear_log();
        bus_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            store(32'h1000 + 32'(i * 16), pat(8'(8'hA0 + i)), 16'(1 << i), 1'b1);
            expect_wr(32'h1000 + 32'(i * 16), 16'(1 << i),
                      lay('0, pat(8'(8'hA0 + i)), 16'(1 << i)));
        end
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h2000; st_data = pat(8'hC0); st_be = 16'hFFFF;
        #1;
        chk(st_ready == 1'b0, "R8 full refuses", st_ready, 0);
        repeat (2) @(negedge clk);
        #1;
        chk(st_ready == 1'b0, "R8 still refused", st_ready, 0);
        @(negedge clk); bus_ready = 1'b1;
        @(negedge clk); bus_ready = 1'b0; #1;
        chk(nw == 1, "R8 one drained", nw, 1);
        chk(st_ready == 1'b1, "R8 room after drain", st_ready, 1);
        @(posedge clk);
        idle();
        expect_wr(32'h2000, 16'hFFFF, pat(8'hC0));
        drain("R8 drain");
        verify("R8 full order");
    endtask

    // R3, R10: pass-through under each gating condition and behind a queue
    task automatic t_bypass();
        clear_log();
        bus_ready = 1'b0;
        cfg_buf_en = 1'b0;
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h900; st_data = pat(8'hD0); st_be = 16'h0F0F; st_bufable = 1'b1;
        #1;
        chk(bus_valid == 1'b1, "R3 pass same cycle", bus_valid, 1);
        chk(bus_addr == 32'h900, "R3 pass addr", bus_addr, 32'h900);
        chk(st_ready == 1'b0, "R3 ready follows bus", st_ready, 0);
        chk(wb_empty == 1'b0, "R10 busy on pass", wb_empty, 0);
        @(negedge clk); bus_ready = 1'b1; #1;
        chk(st_ready == 1'b1, "R3 ready follows bus", st_ready, 1);
        @(posedge clk);
        idle();
        expect_wr(32'h900, 16'h0F0F, lay('0, pat(8'hD0), 16'h0F0F));
        cfg_buf_en = 1'b1; cfg_xlat_en = 1'b0;
        store(32'hC00, pat(8'hD1), 16'h00FF, 1'b1);
        idle();
        expect_wr(32'hC00, 16'h00FF, lay('0, pat(8'hD1), 16'h00FF));
        cfg_xlat_en = 1'b1;
        store(32'hD00, pat(8'hD2), 16'hFF00, 1'b0);
        idle();
        expect_wr(32'hD00, 16'hFF00, lay('0, pat(8'hD2), 16'hFF00));
        #1;
        chk(wb_empty == 1'b1, "R10 empty after pass", wb_empty, 1);
        bus_ready = 1'b0;
        store(32'hA00, pat(8'hD3), 16'h00FF, 1'b1);
        @(negedge clk);
        st_addr = 32'hB00; st_data = pat(8'hD4); st_be = 16'hF0F0; st_bufable = 1'b0;
        #1;
        chk(st_ready == 1'b0, "R3 pass waits for queue", st_ready, 0);
        chk(bus_addr == 32'hA00, "R3 queued head shown", bus_addr, 32'hA00);
        @(negedge clk); bus_ready = 1'b1; #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        idle();
        st_bufable = 1'b1;
        expect_wr(32'hA00, 16'h00FF, lay('0, pat(8'hD3), 16'h00FF));
        expect_wr(32'hB00, 16'hF0F0, lay('0, pat(8'hD4), 16'hF0F0));
        drain("R3 drain");
        verify("R3 pass order");
    endtask

    // R9, R10: flush stalls stores until everything drained
    task automatic t_flush();
        bit gone = 1'b0;
        clear_log();
        bus_ready = 1'b0;
        store(32'h3000, pat(8'hE0), 16'h000F, 1'b1);
        store(32'h3010, pat(8'hE1), 16'h00F0, 1'b1);
        @(negedge clk);
        st_valid = 1'b0; flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        st_valid = 1'b1; st_addr = 32'h3020; st_data = pat(8'hE2); st_be = 16'hF000; st_bufable = 1'b1;
        #1;
        chk(flush_busy == 1'b1, "R9 busy raised", flush_busy, 1);
        chk(st_ready == 1'b0, "R9 store stalled", st_ready, 0);
        chk(wb_empty == 1'b0, "R10 not empty", wb_empty, 0);
        @(negedge clk); bus_ready = 1'b1;
        for (int k = 0; k < 20 && !gone; k++) begin
            @(negedge clk); #1;
            if (!flush_busy) gone = 1'b1;
        end
        chk(gone, "R9 busy falls", flush_busy, 0);
        chk(nw == 2, "R9 all drained", nw, 2);
        chk(wb_empty == 1'b1, "R10 empty at flush end", wb_empty, 1);
        @(posedge clk);
        idle();
        expect_wr(32'h3000, 16'h000F, lay('0, pat(8'hE0), 16'h000F));
        expect_wr(32'h3010, 16'h00F0, lay('0, pat(8'hE1), 16'h00F0));
        expect_wr(32'h3020, 16'hF000, lay('0, pat(8'hE2), 16'hF000));
        drain("R9 drain");
        verify("R9 flush order");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_merge();
        t_head();
        t_nomerge();
        t_full();
        t_bypass();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule